// File: doc/BRIEF.md
# Line-Controlled UART Transmitter

This block is the transmit half of an asynchronous serial port. A single packed control word sets everything about the line: the bit-rate divisor, the character length, parity, the number of stop bits, a line break, and whether the transmit queue is deep or a single byte. Software-side logic writes the control word through one strobe and pushes characters through a second strobe. The block serialises each character onto `txd`, least significant bit first.

The bit rate comes from the block clock. A programmable prescaler divides the clock by the divisor plus one, and a fixed 16x stage divides that again. One input selects whether a divisor of zero is a legal setting for the fastest rate or is refused.

The output pin carries the complement of the conventional line. It rests low. The start bit is high. Data and parity bits appear inverted, and stop bits are low. A break drives the pin high at once. Any other control change waits for the next character boundary, so a frame already on the wire keeps the format it started with.

Top module: `uart_tx_linectl`

## Requirements
- R1: The control word packs the divisor in bits 11:0, break in bit 12, parity enable in bit 13, even-parity select in bit 14, two-stop select in bit 15, queue enable in bit 16 and the length code in bits 18:17. After reset the divisor is 1 and every other field is 0.
- R2: Every serial bit lasts exactly 16 x (divisor + 1) clock cycles.
- R3: When `zero_div_ok` is low, a control write whose divisor field is 0 keeps the previous divisor and still applies its other fields. When `zero_div_ok` is high, divisor 0 is accepted and gives a 16-cycle bit.
- R4: `txd` idles low. Each frame starts with one high start bit, then sends the data bits least significant first, each driven as the complement of its value.
- R5: Length code 0, 1, 2 and 3 sends 5, 6, 7 and 8 data bits respectively. Bits of a written byte above the selected length have no effect on the line.
- R6: With parity enabled, one parity bit follows the data. It makes the count of ones over data plus parity even when the select bit is 1 and odd when it is 0, and it appears complemented on the pin. With parity disabled no parity bit is sent, whatever the select bit holds.
- R7: One low stop bit ends each frame, or two when the two-stop bit is set.
- R8: The cycle after a control write with break set, `txd` is high, and it stays high while break stays set, even during a frame.
- R9: With the queue enabled, 16 characters can wait. `tx_full` rises when the sixteenth is stored.
- R10: With the queue disabled, one waiting character makes `tx_full` high.
- R11: A character written while `tx_full` is high is discarded and never sent, and `tx_overflow` goes high and stays high until reset.
- R12: A control write other than break that lands during a frame leaves that frame unchanged and takes effect from the next character.
- R13: `tx_busy` is high while a character waits or a frame is on the line, and low otherwise.
- R14: After reset `txd`, `tx_busy`, `tx_full` and `tx_overflow` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block and bit-rate reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zero_div_ok | input | 1 | High: divisor 0 is a legal setting |
| ctrl_we | input | 1 | Control-word write strobe |
| ctrl_wdata | input | 19 | Packed control word |
| data_we | input | 1 | Character write strobe |
| data_wdata | input | 8 | Character to send |
| tx_full | output | 1 | Queue cannot take another character |
| tx_busy | output | 1 | Characters waiting or frame in progress |
| tx_overflow | output | 1 | Sticky: a write was discarded |
| txd | output | 1 | Serial output, complemented line |

## Verification
The framer runs through a table of settings. Each entry pairs a length code and a parity, select and stop combination with a character whose bit pattern makes a wrong length, a bit-order error, a swapped parity sense or a missing stop bit show up at a different sampled position. The bit length is timed on a start bit followed by a low pin, at several divisors, with the zero-divisor mode both on and off. Directed runs cover the cases the table cannot reach: the queue filled to depth in both capacities, a discarded write that must never reach the line, a break asserted in the middle of a frame, and a control change landing between two queued characters.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;

  localparam int DIV_W = 12;

  // Field order is the register layout (msb first).
  typedef struct packed {
    logic [1:0]       wlen;
    logic             fifo_en;
    logic             xstop;
    logic             even;
    logic             par_en;
    logic             brk;
    logic [DIV_W-1:0] div;
  } lc_cfg_t;

  localparam int CTRL_W  = $bits(lc_cfg_t);
  localparam int BRK_BIT = DIV_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

endpackage

// File: rtl/uart_lc_baud.sv
module uart_lc_baud #(
  parameter int DIV_W = 12,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bit_tick
);
  localparam int SUB_W  = $clog2(OVS);
  localparam int SPAN_W = DIV_W + SUB_W + 1;

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             tick16;

  always_comb begin
    pre_d    = pre_q;
    sub_d    = sub_q;
    tick16   = 1'b0;
    bit_tick = 1'b0;
    if (!run) begin
      pre_d = '0;
      sub_d = '0;
    end else if (pre_q == div) begin
      tick16 = 1'b1;
      pre_d  = '0;
      if (sub_q == SUB_W'(OVS - 1)) begin
        sub_d    = '0;
        bit_tick = 1'b1;
      end else begin
        sub_d = sub_q + SUB_W'(1);
      end
    end else begin
      pre_d = pre_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= pre_d;
      sub_q <= sub_d;
    end
  end

  // Checker: independent span counter between bit ticks.
  logic [SPAN_W-1:0] span_q;
  logic [SPAN_W-1:0] span_exp;
  assign span_exp = ((SPAN_W'(div) + SPAN_W'(1)) * SPAN_W'(OVS)) - SPAN_W'(1);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)               span_q <= '0;
    else if (!run || bit_tick) span_q <= '0;
    else                       span_q <= span_q + SPAN_W'(1);
  end

  assert_bit_span_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    bit_tick |-> span_q == span_exp);

  assert_tick_needs_sub_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    bit_tick |-> tick16);

endmodule

// File: rtl/uart_lc_fifo.sv
module uart_lc_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         deep,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          accept, take;

  assign empty  = (cnt_q == '0);
  assign full   = deep ? (cnt_q == CW'(DEPTH)) : !empty;
  assign accept = wr && !full;
  assign take   = rd && !empty;
  assign rdata  = mem[rptr_q];
  assign ovf    = ovf_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q | (wr && full);
    if (accept) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    if (take)   rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    if (accept && !take)      cnt_d = cnt_q + CW'(1);
    else if (take && !accept) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr_q] <= wdata;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  assert_drop_keeps_count_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr && full && !rd) |=> cnt_q == $past(cnt_q));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_q |=> ovf_q);

  assert_single_slot_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!deep && wr && !empty) |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/uart_lc_framer.sv
module uart_lc_framer
  import uart_lc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [1:0]   wlen,
  input  logic         par_en,
  input  logic         even,
  input  logic         xstop,
  input  logic         avail,
  input  logic [W-1:0] byte_in,
  input  logic         bit_tick,
  output logic         pop,
  output logic         run,
  output logic         line
);
  tx_state_t    st_q, st_d;
  logic [W-1:0] sh_q, sh_d;
  logic [2:0]   bc_q, bc_d;
  logic         par_q, par_d;
  logic         sc_q, sc_d;
  logic [3:0]   nbits;
  logic         last_bit;

  assign nbits    = 4'd5 + {2'b00, wlen};
  assign last_bit = ({1'b0, bc_q} == (nbits - 4'd1));
  assign run      = (st_q != ST_IDLE);

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    bc_d  = bc_q;
    par_d = par_q;
    sc_d  = sc_q;
    pop   = 1'b0;
    case (st_q)
      ST_IDLE: if (avail) begin
        pop   = 1'b1;
        sh_d  = byte_in;
        bc_d  = '0;
        par_d = 1'b0;
        st_d  = ST_START;
      end
      ST_START: if (bit_tick) st_d = ST_DATA;
      ST_DATA: if (bit_tick) begin
        par_d = par_q ^ sh_q[0];
        sh_d  = sh_q >> 1;
        if (last_bit) begin
          sc_d = 1'b0;
          st_d = par_en ? ST_PAR : ST_STOP;
        end else begin
          bc_d = bc_q + 3'd1;
        end
      end
      ST_PAR: if (bit_tick) begin
        sc_d = 1'b0;
        st_d = ST_STOP;
      end
      ST_STOP: if (bit_tick) begin
        if (xstop && !sc_q) sc_d = 1'b1;
        else                st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_q)
      ST_START: line = 1'b1;
      ST_DATA:  line = ~sh_q[0];
      ST_PAR:   line = ~(even ? par_q : ~par_q);
      default:  line = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      bc_q  <= '0;
      par_q <= 1'b0;
      sc_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      bc_q  <= bc_d;
      par_q <= par_d;
      sc_q  <= sc_d;
    end
  end

  assert_bitcnt_range_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_DATA) |-> ({1'b0, bc_q} < nbits));

  assert_start_after_pop_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |=> (st_q == ST_START));

  assert_parity_only_enabled_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_PAR) |-> par_en);

endmodule

// File: rtl/uart_tx_linectl.sv
module uart_tx_linectl
  import uart_lc_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_div_ok,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              data_we,
  input  logic [7:0]        data_wdata,
  output logic              tx_full,
  output logic              tx_busy,
  output logic              tx_overflow,
  output logic              txd
);
  localparam int      DW        = 8;
  localparam lc_cfg_t RESET_CFG = lc_cfg_t'({{(CTRL_W - DIV_W){1'b0}}, DIV_W'(1)});

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // Pending word (written) and active word (frozen per frame).
  lc_cfg_t pend_q, pend_d, act_q, act_d, wr_cfg;
  logic    run, pop, empty, line, bit_tick;
  logic [DW-1:0] head;

  assign wr_cfg = lc_cfg_t'(ctrl_wdata);

  always_comb begin
    pend_d = pend_q;
    if (ctrl_we) begin
      pend_d = wr_cfg;
      if (!zero_div_ok && (wr_cfg.div == '0)) pend_d.div = pend_q.div;
    end
    act_d = run ? act_q : pend_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RESET_CFG;
      act_q  <= RESET_CFG;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  uart_lc_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_fifo (
    .clk    (clk),
    .rst_ni (rst_ni),
    .deep   (act_q.fifo_en),
    .wr     (data_we),
    .wdata  (data_wdata),
    .rd     (pop),
    .rdata  (head),
    .empty  (empty),
    .full   (tx_full),
    .ovf    (tx_overflow)
  );

  uart_lc_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .run      (run),
    .div      (act_q.div),
    .bit_tick (bit_tick)
  );

  uart_lc_framer #(.W(DW)) u_framer (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .wlen     (act_q.wlen),
    .par_en   (act_q.par_en),
    .even     (act_q.even),
    .xstop    (act_q.xstop),
    .avail    (!empty),
    .byte_in  (head),
    .bit_tick (bit_tick),
    .pop      (pop),
    .run      (run),
    .line     (line)
  );

  assign tx_busy = run || !empty;
  assign txd     = pend_q.brk ? 1'b1 : line;

  assert_break_now_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_we && ctrl_wdata[BRK_BIT]) |=> txd);

  assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && $past(run)) |-> $stable(act_q));

  assert_zero_div_kept_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_we && !zero_div_ok && (ctrl_wdata[DIV_W-1:0] == '0)) |=> pend_q.div == $past(pend_q.div));

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tx_busy && !pend_q.brk) |-> !txd);

endmodule

// File: tb/uart_tx_linectl_test.sv
module uart_tx_linectl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        zero_div_ok;
  logic        ctrl_we;
  logic [18:0] ctrl_wdata;
  logic        data_we;
  logic [7:0]  data_wdata;
  logic        tx_full, tx_busy, tx_overflow, txd;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_tx_linectl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .zero_div_ok (zero_div_ok),
    .ctrl_we     (ctrl_we),
    .ctrl_wdata  (ctrl_wdata),
    .data_we     (data_we),
    .data_wdata  (data_wdata),
    .tx_full     (tx_full),
    .tx_busy     (tx_busy),
    .tx_overflow (tx_overflow),
    .txd         (txd)
  );

  // Table entry: {wlen[13:12], par_en[11], even[10], xstop[9], fifo_en[8], data[7:0]}
  localparam logic [13:0] VEC [0:7] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3D},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3D},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE5},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7F},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h81},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h96},
    {2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h1B}
  };

  function automatic logic [18:0] mk(input int dv, input bit br, input bit pe,
                                     input bit ev, input bit xs, input bit fe,
                                     input logic [1:0] wl);
    logic [11:0] d12;
    d12 = dv[11:0];
    return {wl, fe, xs, ev, pe, br, d12};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; zero_div_ok = 1'b1; ctrl_we = 1'b0; ctrl_wdata = '0;
    data_we = 1'b0; data_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [18:0] w);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = w;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic write_data(input logic [7:0] b);
    @(negedge clk); data_we = 1'b1; data_wdata = b;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int c = 0; c < 20000 && tx_busy; c++) @(negedge clk);
  endtask

  // Waits for a start bit, samples each bit mid-period, compares with the expected pin levels.
  task automatic capture(input int nb, input bit pen, input bit ev, input bit two,
                         input int per, input logic [7:0] d, input string req);
    logic [11:0] got, exp;
    logic [7:0]  dm;
    logic        pbit;
    int          n;
    bit          seen;
    got = '0; exp = '0;
    dm = d & 8'((1 << nb) - 1);
    exp[0] = 1'b1;
    for (int i = 0; i < nb; i++) exp[1 + i] = ~dm[i];
    n = 1 + nb;
    if (pen) begin
      pbit = ev ? ^dm : ~^dm;
      exp[n] = ~pbit;
      n++;
    end
    exp[n] = 1'b0; n++;
    if (two) begin exp[n] = 1'b0; n++; end
    seen = 1'b0;
    for (int c = 0; c < 20000 && !seen; c++) begin
      @(negedge clk);
      if (txd) seen = 1'b1;
    end
    repeat (per / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      if (i < n - 1) repeat (per) @(negedge clk);
    end
    chk(seen && (got == exp), req, "frame bits", got, exp);
  endtask

  task automatic measure(output int cnt);
    bit seen;
    seen = 1'b0;
    cnt = 0;
    for (int c = 0; c < 20000 && !seen; c++) begin
      @(negedge clk);
      if (txd) seen = 1'b1;
    end
    while (seen && txd && cnt < 100000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int per;
    int ones;
    do_reset();

    // R14: reset state
    chk(txd == 1'b0, "R14", "txd", txd, 0);
    chk(tx_busy == 1'b0, "R14", "busy", tx_busy, 0);
    chk(tx_full == 1'b0, "R14", "full", tx_full, 0);
    chk(tx_overflow == 1'b0, "R14", "overflow", tx_overflow, 0);

    // R1 R4 R5 R6 R7 R13: table of formats at divisor 1 (32-cycle bit)
    for (int v = 0; v < 8; v++) begin
      logic [13:0] e;
      e = VEC[v];
      write_ctrl(mk(1, 1'b0, e[11], e[10], e[9], e[8], e[13:12]));
      repeat (3) @(negedge clk);
      fork
        capture(5 + int'(e[13:12]), e[11], e[10], e[9], 32, e[7:0], "R1/R4/R5/R6/R7");
        write_data(e[7:0]);
      join
      chk(tx_busy == 1'b1, "R13", "busy during stop", tx_busy, 1);
      wait_idle();
      chk(tx_busy == 1'b0 && txd == 1'b0, "R13", "idle after frame", {tx_busy, txd}, 0);
    end

    // R2: divisor 3 gives 64-cycle bits
    write_ctrl(mk(3, 0, 0, 0, 0, 0, 2'd3));
    repeat (3) @(negedge clk);
    fork measure(per); write_data(8'h01); join
    chk(per == 64, "R2", "bit length div3", per, 64);
    wait_idle();

    // R3: zero refused when mode low, accepted when high
    zero_div_ok = 1'b0;
    write_ctrl(mk(0, 0, 0, 0, 0, 0, 2'd3));
    repeat (3) @(negedge clk);
    fork measure(per); write_data(8'h01); join
    chk(per == 64, "R3", "zero divisor refused", per, 64);
    wait_idle();
    zero_div_ok = 1'b1;
    write_ctrl(mk(0, 0, 0, 0, 0, 0, 2'd3));
    repeat (3) @(negedge clk);
    fork measure(per); write_data(8'h01); join
    chk(per == 16, "R3", "zero divisor accepted", per, 16);
    wait_idle();

    // R8: break mid-frame
    write_ctrl(mk(1, 0, 0, 0, 0, 0, 2'd3));
    repeat (3) @(negedge clk);
    write_data(8'hFF);
    repeat (100) @(negedge clk);
    write_ctrl(mk(1, 1, 0, 0, 0, 0, 2'd3));
    chk(txd == 1'b1, "R8", "break immediate", txd, 1);
    ones = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (txd) ones++;
    end
    chk(ones == 200, "R8", "break held", ones, 200);
    write_ctrl(mk(1, 0, 0, 0, 0, 0, 2'd3));
    wait_idle();
    chk(txd == 1'b0, "R8", "line idle after break", txd, 0);

    // R10 R11: single-byte buffer, third write dropped
    do_reset();
    write_ctrl(mk(1, 0, 0, 0, 0, 0, 2'd3));
    repeat (3) @(negedge clk);
    fork
      begin
        capture(8, 0, 0, 0, 32, 8'hC3, "R10");
        capture(8, 0, 0, 0, 32, 8'h3C, "R10");
      end
      begin
        write_data(8'hC3);
        repeat (3) @(negedge clk);
        chk(tx_full == 1'b0, "R10", "empty slot not full", tx_full, 0);
        write_data(8'h3C);
        chk(tx_full == 1'b1, "R10", "one byte full", tx_full, 1);
        write_data(8'h99);
        chk(tx_overflow == 1'b1, "R11", "overflow set", tx_overflow, 1);
      end
    join
    ones = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (txd) ones++;
    end
    chk(ones == 0, "R11", "dropped byte not sent", ones, 0);
    chk(tx_overflow == 1'b1, "R11", "overflow sticky", tx_overflow, 1);

    // R9: deep queue of 16
    do_reset();
    write_ctrl(mk(1, 0, 0, 0, 0, 1, 2'd3));
    repeat (3) @(negedge clk);
    for (int k = 0; k < 16; k++) write_data(8'(k));
    chk(tx_full == 1'b0, "R9", "15 waiting not full", tx_full, 0);
    write_data(8'h10);
    chk(tx_full == 1'b1, "R9", "16 waiting full", tx_full, 1);
    chk(tx_overflow == 1'b0, "R9", "no overflow at depth", tx_overflow, 0);
    write_data(8'h11);
    chk(tx_overflow == 1'b1, "R11", "overflow when deep full", tx_overflow, 1);
    wait_idle();
    chk(tx_busy == 1'b0, "R9", "queue drains", tx_busy, 0);

    // R12: control change mid-frame applies to the next character
    do_reset();
    write_ctrl(mk(1, 0, 0, 0, 0, 1, 2'd3));
    repeat (3) @(negedge clk);
    fork
      begin
        capture(8, 0, 0, 0, 32, 8'h5A, "R12");
        capture(5, 1, 0, 0, 32, 8'h13, "R12");
      end
      begin
        write_data(8'h5A);
        write_data(8'h13);
        repeat (60) @(negedge clk);
        write_ctrl(mk(1, 0, 1, 0, 0, 1, 2'd0));
      end
    join
    wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule